// File: doc/BRIEF.md
# Memory Operand Effective Address Generator

This block turns the already-decoded addressing fields of one memory operand into a 64-bit effective address. It receives the mode/register/memory byte, an optional scale/index/base byte with a flag saying whether that byte was present, the two register-extension prefix bits that widen the base and index register numbers, a displacement that the decoder has already sign-extended to 64 bits, and a flag that says whether the core runs in 64-bit mode. It reads the general register file through two combinational read ports: one for the base (or direct) register and one for the index register.

A one-cycle `start` strobe launches a computation. The register numbers appear on the read-address ports in the same cycle, and the register file answers within that cycle. On the next clock edge the block registers either a valid address or an error. An error means that the operand needs one of the upper eight registers while the core is not in 64-bit mode. The block also handles the encodings that stand for "no index" and "no base". All sums wrap modulo 2^64.

Top module: `eff_addr_gen`

## Requirements
- R1: While reset (`rstN` low) is applied, and after it is released before any strobe, `addrValid` and `addrError` are 0 and `addr` is 0.
- R2: One cycle after `start`, exactly one of `addrValid` and `addrError` is 1, for that single cycle. In a cycle that does not follow `start`, both are 0 and `addr` keeps its last value.
- R3: When the mode field (bits 7:6 of `modrm`) equals 3, `addr` is the register numbered {`rexB`, `modrm[2:0]`}. No displacement is added, and `sibPresent`, `sib` and `rexX` have no effect.
- R4: When mode is not 3 and `sibPresent` is 0, `addr` is the register numbered {`rexB`, `modrm[2:0]`} plus `disp`.
- R5: When mode is not 3 and `sibPresent` is 1, `addr` = base + (index << `sib[7:6]`) + `disp`. The base register is {`rexB`, `sib[2:0]`} and the index register is {`rexX`, `sib[5:3]`}.
- R6: If the extended index number {`rexX`, `sib[5:3]`} equals 4, the index term is zero. With `rexX` = 1 the number is 12, which is a real register.
- R7: If mode is 0 and the raw field `sib[2:0]` equals 5, the base term is zero and only index and displacement are summed. In this case `rexB` is not used.
- R8: When `longMode` is 0, any register number from 8 to 15 that the address actually uses raises `addrError`, and `addr` becomes all ones.
- R9: All additions and the scaling wrap modulo 2^64.
- R10: Registers are numbered 0..15 in the order AX, CX, DX, BX, SP, BP, SI, DI, R8..R15. During the `start` cycle, `rfRdAddrA` carries the base or direct register number and `rfRdAddrB` carries the index register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a computation this cycle |
| modrm | input | 8 | Mode/register/memory byte |
| sibPresent | input | 1 | Scale/index/base byte is present |
| sib | input | 8 | Scale/index/base byte |
| rexB | input | 1 | Extension bit for base / direct register |
| rexX | input | 1 | Extension bit for index register |
| longMode | input | 1 | Core runs in 64-bit mode |
| disp | input | 64 | Sign-extended displacement |
| rfRdAddrA | output | 4 | Register file read address, base/direct |
| rfRdDataA | input | 64 | Register file read data, base/direct |
| rfRdAddrB | output | 4 | Register file read address, index |
| rfRdDataB | input | 64 | Register file read data, index |
| addr | output | 64 | Effective address |
| addrValid | output | 1 | Address valid (one cycle) |
| addrError | output | 1 | Invalid register for the current mode (one cycle) |

## Verification
A first sweep runs every one of the 256 mode/register/memory values against both prefix bits and both execution modes, with the scale/index/base byte present on alternate codes. This separates the direct-register form from the memory forms with and without that byte, and shows that extension bits cause errors outside 64-bit mode. A second sweep runs every value of the scale/index/base byte under each memory mode, so the no-index code (with and without the index extension), the no-base code (only under mode 0), and all four scales are each visited. Register contents and displacements are random 64-bit values, which makes wrap-around common, and one directed case forces an overflow on purpose. Idle cycles between strobes show that nothing moves without `start`.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int unsigned XLEN      = 64;
  localparam int unsigned REG_CNT   = 16;
  localparam int unsigned REG_W     = $clog2(REG_CNT);
  localparam int unsigned LEGACY_CNT = 8;

  localparam logic [1:0] MODE_REG = 2'd3;
  localparam logic [1:0] MODE_NODISP = 2'd0;
  localparam logic [2:0] IDX_NONE_CODE = 3'd4;
  localparam logic [2:0] BASE_NONE_CODE = 3'd5;

  typedef struct packed {
    logic       load;
    logic       fault;
    logic       baseEn;
    logic       idxEn;
    logic       dispEn;
    logic [1:0] scale;
  } eagStrobe_t;
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
#(
  parameter int unsigned REG_NUM  = REG_CNT,
  parameter int unsigned LOW_REGS = LEGACY_CNT,
  localparam int unsigned RW = $clog2(REG_NUM)
) (
  input  logic          start,
  input  logic [7:0]    modrm,
  input  logic          sibPresent,
  input  logic [7:0]    sib,
  input  logic          rexB,
  input  logic          rexX,
  input  logic          longMode,
  output logic [RW-1:0] baseNum,
  output logic [RW-1:0] idxNum,
  output eagStrobe_t    stb
);
  logic [1:0] modeField;
  logic [2:0] rmField;
  logic [2:0] sibBase;
  logic [2:0] sibIdx;
  logic       regForm;
  logic       useSib;
  logic       baseNone;
  logic       idxNone;
  logic       baseBad;
  logic       idxBad;
  logic       baseUsed;
  logic       idxUsed;

  assign modeField = modrm[7:6];
  assign rmField   = modrm[2:0];
  assign sibBase   = sib[2:0];
  assign sibIdx    = sib[5:3];

  assign regForm = (modeField == MODE_REG);
  assign useSib  = !regForm && sibPresent;

  always_comb begin
    baseNum = '0;
    idxNum  = '0;
    if (useSib) begin
      baseNum = RW'({rexB, sibBase});
      idxNum  = RW'({rexX, sibIdx});
    end else begin
      baseNum = RW'({rexB, rmField});
      idxNum  = '0;
    end
  end

  // Encodings that remove a term from the sum
  assign baseNone = useSib && (modeField == MODE_NODISP) && (sibBase == BASE_NONE_CODE);
  assign idxNone  = useSib && (idxNum == RW'(IDX_NONE_CODE));

  assign baseUsed = !baseNone;
  assign idxUsed  = useSib && !idxNone;

  // Upper registers exist only in 64-bit mode
  assign baseBad = baseUsed && !longMode && (int'(baseNum) >= int'(LOW_REGS));
  assign idxBad  = idxUsed  && !longMode && (int'(idxNum)  >= int'(LOW_REGS));

  always_comb begin
    stb        = '0;
    stb.load   = start;
    stb.fault  = baseBad || idxBad;
    stb.baseEn = baseUsed;
    stb.idxEn  = idxUsed;
    stb.dispEn = !regForm;
    stb.scale  = useSib ? sib[7:6] : 2'd0;
  end
endmodule

// File: rtl/eag_datapath.sv
module eag_datapath
  import eag_pkg::*;
#(
  parameter int unsigned WIDTH = XLEN
) (
  input  logic             clk,
  input  logic             rstN,
  input  eagStrobe_t       stb,
  input  logic [WIDTH-1:0] baseVal,
  input  logic [WIDTH-1:0] idxVal,
  input  logic [WIDTH-1:0] dispVal,
  output logic [WIDTH-1:0] addrQ,
  output logic             validQ,
  output logic             errorQ
);
  localparam int unsigned SCALES = 4;

  logic [WIDTH-1:0] baseTerm;
  logic [WIDTH-1:0] idxRaw;
  logic [WIDTH-1:0] idxTerm;
  logic [WIDTH-1:0] dispTerm;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] scaled [SCALES];

  assign baseTerm = stb.baseEn ? baseVal : '0;
  assign idxRaw   = stb.idxEn  ? idxVal  : '0;
  assign dispTerm = stb.dispEn ? dispVal : '0;

  for (genvar s = 0; s < SCALES; s++) begin : g_scale
    assign scaled[s] = idxRaw << s;
  end

  assign idxTerm = scaled[stb.scale];
  assign sum     = baseTerm + idxTerm + dispTerm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      validQ <= 1'b0;
      errorQ <= 1'b0;
    end else begin
      validQ <= stb.load && !stb.fault;
      errorQ <= stb.load && stb.fault;
      if (stb.load) begin
        addrQ <= stb.fault ? '1 : sum;
      end
    end
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int unsigned XW   = XLEN,
  parameter int unsigned NREG = REG_CNT,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [7:0]    modrm,
  input  logic          sibPresent,
  input  logic [7:0]    sib,
  input  logic          rexB,
  input  logic          rexX,
  input  logic          longMode,
  input  logic [XW-1:0] disp,
  output logic [AW-1:0] rfRdAddrA,
  input  logic [XW-1:0] rfRdDataA,
  output logic [AW-1:0] rfRdAddrB,
  input  logic [XW-1:0] rfRdDataB,
  output logic [XW-1:0] addr,
  output logic          addrValid,
  output logic          addrError
);
  eagStrobe_t stb;

  eag_ctrl #(.REG_NUM(NREG), .LOW_REGS(LEGACY_CNT)) ctrl_i (
    .start      (start),
    .modrm      (modrm),
    .sibPresent (sibPresent),
    .sib        (sib),
    .rexB       (rexB),
    .rexX       (rexX),
    .longMode   (longMode),
    .baseNum    (rfRdAddrA),
    .idxNum     (rfRdAddrB),
    .stb        (stb)
  );

  eag_datapath #(.WIDTH(XW)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .baseVal (rfRdDataA),
    .idxVal  (rfRdDataB),
    .dispVal (disp),
    .addrQ   (addr),
    .validQ  (addrValid),
    .errorQ  (addrError)
  );
endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int unsigned XW = 64,
  parameter int unsigned AW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [7:0]    modrm,
  input logic          rexB,
  input logic          longMode,
  input logic [AW-1:0] rfRdAddrA,
  input logic [XW-1:0] rfRdDataA,
  input logic [XW-1:0] addr,
  input logic          addrValid,
  input logic          addrError
);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (addrValid ^ addrError));

  assert_quiet_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (!addrValid && !addrError && $stable(addr)));

  assert_reg_form_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    (start && modrm[7:6] == 2'd3 && longMode) |=> (addrValid && addr == $past(rfRdDataA)));

  assert_error_all_ones_R8: assert property (@(posedge clk) disable iff (!rstN)
    addrError |-> (addr == {XW{1'b1}}));

  assert_upper_reg_fault_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && modrm[7:6] == 2'd3 && rexB && !longMode) |=> addrError);

  assert_read_port_number_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && modrm[7:6] == 2'd3) |-> (rfRdAddrA == AW'({rexB, modrm[2:0]})));
endmodule

bind eff_addr_gen eag_checker #(.XW(XW), .AW(AW)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .modrm     (modrm),
  .rexB      (rexB),
  .longMode  (longMode),
  .rfRdAddrA (rfRdAddrA),
  .rfRdDataA (rfRdDataA),
  .addr      (addr),
  .addrValid (addrValid),
  .addrError (addrError)
);

// File: tb/eff_addr_gen_tb_top.sv
module eff_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  modrm = '0;
  logic        sibPresent = 1'b0;
  logic [7:0]  sib = '0;
  logic        rexB = 1'b0;
  logic        rexX = 1'b0;
  logic        longMode = 1'b1;
  logic [63:0] disp = '0;
  logic [3:0]  rfRdAddrA, rfRdAddrB;
  logic [63:0] rfRdDataA, rfRdDataB;
  logic [63:0] addr;
  logic        addrValid, addrError;

  logic [63:0] regs [16];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rfRdDataA = regs[rfRdAddrA];
  assign rfRdDataB = regs[rfRdAddrB];

  eff_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .start(start), .modrm(modrm),
    .sibPresent(sibPresent), .sib(sib), .rexB(rexB), .rexX(rexX),
    .longMode(longMode), .disp(disp),
    .rfRdAddrA(rfRdAddrA), .rfRdDataA(rfRdDataA),
    .rfRdAddrB(rfRdAddrB), .rfRdDataB(rfRdDataB),
    .addr(addr), .addrValid(addrValid), .addrError(addrError)
  );

  task automatic check(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (modrm=%h sib=%h sp=%0d b=%0d x=%0d lm=%0d)",
               tag, act, exp, modrm, sib, sibPresent, rexB, rexX, longMode);
    end
  endtask

  // Behavioural reference: walks the addressing rules step by step
  function automatic void refModel(input logic [7:0] m, input logic [7:0] s, input bit sp,
                                   input bit rb, input bit rx, input bit lm, input logic [63:0] d,
                                   output logic [63:0] ea, output bit err, output int baseNo,
                                   output string tag);
    int md = int'(m[7:6]);
    int n;
    longint unsigned b = 0;
    longint unsigned ix = 0;
    err = 0; baseNo = -1; ea = '0; tag = "R5";
    if (md == 3) begin
      n = int'(m[2:0]) + (rb ? 8 : 0);
      baseNo = n; tag = "R3";
      if (!lm && n >= 8) err = 1; else ea = regs[n];
    end else if (sp) begin
      if (md == 0 && s[2:0] == 3'd5) begin
        b = 0; tag = "R7";
      end else begin
        n = int'(s[2:0]) + (rb ? 8 : 0);
        baseNo = n;
        if (!lm && n >= 8) err = 1; else b = regs[n];
      end
      n = int'(s[5:3]) + (rx ? 8 : 0);
      if (n == 4) begin
        ix = 0; tag = "R6";
      end else if (!lm && n >= 8) err = 1;
      else ix = regs[n];
      ea = b + ix * (longint'(1) << s[7:6]) + d;
    end else begin
      n = int'(m[2:0]) + (rb ? 8 : 0);
      baseNo = n; tag = "R4";
      if (!lm && n >= 8) err = 1; else ea = regs[n] + d;
    end
    if (err) begin
      ea = '1; tag = "R8";
    end
  endfunction

  task automatic runOp(input logic [7:0] m, input logic [7:0] s, input bit sp,
                       input bit rb, input bit rx, input bit lm, input logic [63:0] d);
    logic [63:0] expEa;
    bit expErr;
    int bn;
    string tag;
    refModel(m, s, sp, rb, rx, lm, d, expEa, expErr, bn, tag);
    @(negedge clk);
    modrm = m; sib = s; sibPresent = sp; rexB = rb; rexX = rx; longMode = lm; disp = d;
    start = 1'b1;
    #1;
    if (bn >= 0) check("R10 read port", rfRdAddrA == 4'(bn), 64'(rfRdAddrA), 64'(bn));
    @(negedge clk);
    start = 1'b0;
    check({tag, " outcome"}, addrValid == !expErr && addrError == expErr,
          {62'd0, addrValid, addrError}, {62'd0, !expErr, expErr});
    check({tag, " address"}, addr == expEa, addr, expEa);
    @(negedge clk);
    check("R2 idle", !addrValid && !addrError && addr == expEa, addr, expEa);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = {$urandom, $urandom};
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", addr == '0 && !addrValid && !addrError, addr, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", addr == '0 && !addrValid && !addrError, addr, '0);

    // R9: forced wrap-around
    regs[3] = 64'hFFFF_FFFF_FFFF_FFF0;
    regs[6] = 64'h8000_0000_0000_0001;
    runOp(8'h84, 8'b11_110_011, 1'b1, 1'b0, 1'b0, 1'b1, 64'h20);
    check("R9 wrap", addr == 64'h0000_0000_0000_0018, addr, 64'h18);

    // Sweep every modrm value
    for (int lm = 0; lm < 2; lm++)
      for (int rx = 0; rx < 4; rx++)
        for (int m = 0; m < 256; m++)
          runOp(8'(m), 8'(m) ^ 8'h5A, m[0], rx[0], rx[1], lm[0], {$urandom, $urandom});

    // Sweep every sib value under each memory mode
    for (int lm = 0; lm < 2; lm++)
      for (int rx = 0; rx < 4; rx++)
        for (int md = 0; md < 3; md++)
          for (int s = 0; s < 256; s++)
            runOp({2'(md), 3'(s + md), 3'd4}, 8'(s), 1'b1, rx[0], rx[1], lm[0],
                  (s[1] ? 64'hFFFF_FFFF_FFFF_FF80 : {$urandom, $urandom}));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule